// File: doc/BRIEF.md
# Double-Buffered Piecewise-Linear Transfer Curve

This block applies a transfer curve (linearisation or gamma encoding) to the red, green and blue samples of a pixel stream. The curve is piecewise linear. Inside a programmable input window it is read from one of two curve memories. Each memory holds, for every segment and every colour, a base value and a slope (delta) value. The output is the base of the selected segment plus the delta scaled by the position of the input inside that segment. Below the window the output follows a start slope through the origin. Above the window it follows an end slope starting from an end base value. Two fixed built-in curves and a bypass are available as further modes.

A host loads curves through a single data port that steps through the memory on its own. Each host write stores one word. Six consecutive writes fill one segment, and then the port moves to the next segment. The memory that is currently feeding the pixel path cannot be written. A host therefore always loads the idle memory and then switches the mode to it, and the pixel path never sees a half-written curve. A status output tells the host which memory is live.

Top module: `gamma_pwl_lut`

## Requirements
- R1: While reset is held, and after it, the pixel outputs are 0, `pix_valid_o` is 0, `status_o` is 0 and every stored curve word is 0.
- R2: `mode_i` is registered once per clock, and the registered value selects the behaviour. The codes are: 0 bypass, 1 square curve, 2 blended curve, 3 memory A, 4 memory B, and 5 to 7 behave as bypass. `status_o` is 9 while the registered mode is 3, 10 while it is 4, and 0 otherwise.
- R3: In bypass the output equals the input, saturated to the output range. Results appear one clock after a cycle with `pix_valid_i` high, `pix_valid_o` is `pix_valid_i` delayed by one clock, and the outputs hold their value after a cycle without valid input.
- R4: Mode 1 outputs (x*x) >> (2*IN_W-OUT_W). Mode 2 outputs the mode-1 value plus x, shifted right by one.
- R5: Pulsing `idx_clr_i` sets the write position to segment 0, word 0. The words within a segment are written in this order: base red, base green, base blue, delta red, delta green, delta blue. After the sixth word the segment number advances, and it wraps from NSEG-1 to 0. If `idx_clr_i` and `wr_i` are high in the same cycle, the clear wins and the write is dropped.
- R6: `wr_mask_i` bit 0 enables red words, bit 1 green words and bit 2 blue words. A write whose colour bit is 0 leaves the stored word unchanged but still advances the write position.
- R7: `wr_sel_i` 0 targets memory A and 1 targets memory B. A write aimed at the memory that is live (memory A in mode 3, memory B in mode 4) is dropped but still advances the write position.
- R8: In modes 3 and 4, for rgn_start_i <= x < rgn_start_i + NSEG*2^FRAC_W, let off = x - rgn_start_i, i = off >> FRAC_W and f = off mod 2^FRAC_W. The output is base[i] + ((delta[i]*f + 2^(FRAC_W-1)) >> FRAC_W), taken from the live memory.
- R9: In modes 3 and 4, for x < rgn_start_i, the output is (x*start_slope_i + 2^(SLOPE_FRAC-1)) >> SLOPE_FRAC.
- R10: In modes 3 and 4, for x at or above the window end E, the output is end_base_i + (((x-E)*end_slope_i + 2^(SLOPE_FRAC-1)) >> SLOPE_FRAC).
- R11: Every computed output above 2^OUT_W-1 is clamped to 2^OUT_W-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 3 | Curve mode code |
| rgn_start_i | input | IN_W | First input value of the stored window |
| start_slope_i | input | SLOPE_W | Slope below the window, SLOPE_FRAC fraction bits |
| end_base_i | input | OUT_W | Output value at the window end |
| end_slope_i | input | SLOPE_W | Slope above the window, SLOPE_FRAC fraction bits |
| idx_clr_i | input | 1 | Reset the write position to segment 0, word 0 |
| wr_i | input | 1 | Write one word to the data port |
| wr_sel_i | input | 1 | Target memory: 0 A, 1 B |
| wr_mask_i | input | 3 | Colour write enables (bit0 red, bit1 green, bit2 blue) |
| wr_data_i | input | OUT_W | Word to store |
| pix_valid_i | input | 1 | Input pixel valid |
| r_i | input | IN_W | Red input |
| g_i | input | IN_W | Green input |
| b_i | input | IN_W | Blue input |
| pix_valid_o | output | 1 | Output pixel valid |
| r_o | output | OUT_W | Red output |
| g_o | output | OUT_W | Green output |
| b_o | output | OUT_W | Blue output |
| status_o | output | 4 | Live memory code: 9 A, 10 B, 0 none |

## Verification
The hardest situation to create is a host write that lands on the live memory while pixels read that same memory. The bench loads memory A, makes it live, and then streams a complete second curve into A with the pixel path running. It probes the same inputs before and after, so that any leak shows up as changed outputs. The wrap of the write position and a clear issued in the same cycle as a write are reached by writing one segment past the end of memory B and issuing a clear together with a write. The window edges and the clamp are driven with inputs one below the start, exactly at the end and at full scale.

// File: rtl/gamma_pkg.sv
package gamma_pkg;
  typedef enum logic [2:0] {
    MODE_BYPASS = 3'd0,
    MODE_SQUARE = 3'd1,
    MODE_BLEND  = 3'd2,
    MODE_RAM_A  = 3'd3,
    MODE_RAM_B  = 3'd4
  } lut_mode_e;

  localparam logic [3:0] STAT_NONE   = 4'd0;
  localparam logic [3:0] STAT_A_LIVE = 4'd9;
  localparam logic [3:0] STAT_B_LIVE = 4'd10;
  localparam int unsigned WORDS_PER_SEG = 6;
endpackage

// File: rtl/gamma_host_port.sv
module gamma_host_port #(
  parameter int unsigned NSEG  = 16,
  parameter int unsigned IDX_W = $clog2(NSEG)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             wr_i,
  output logic             go_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [2:0]       sub_o
);
  localparam logic [2:0]       SUB_LAST = 3'(gamma_pkg::WORDS_PER_SEG - 1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(NSEG - 1);

  assign go_o = wr_i && !clr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_o <= '0;
      sub_o <= '0;
    end else if (clr_i) begin
      idx_o <= '0;
      sub_o <= '0;
    end else if (wr_i) begin
      if (sub_o == SUB_LAST) begin
        sub_o <= '0;
        idx_o <= (idx_o == IDX_LAST) ? '0 : idx_o + 1'b1;
      end else begin
        sub_o <= sub_o + 1'b1;
      end
    end
  end
endmodule

// File: rtl/gamma_lut_bank.sv
module gamma_lut_bank #(
  parameter int unsigned NSEG  = 16,
  parameter int unsigned W     = 12,
  parameter int unsigned IDX_W = $clog2(NSEG)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  we_i,
  input  logic                  wsel_i,
  input  logic [IDX_W-1:0]      widx_i,
  input  logic [2:0]            wsub_i,
  input  logic [2:0]            wmask_i,
  input  logic [W-1:0]          wdata_i,
  input  logic                  rsel_i,
  input  logic [2:0][IDX_W-1:0] ridx_i,
  output logic [2:0][W-1:0]     base_o,
  output logic [2:0][W-1:0]     delta_o
);
  // [memory][colour][0 base / 1 delta][segment]
  logic [W-1:0] mem [2][3][2][NSEG];
  logic [1:0]   w_ch;
  logic         w_dl;

  always_comb begin
    unique case (wsub_i)
      3'd0:    begin w_ch = 2'd0; w_dl = 1'b0; end
      3'd1:    begin w_ch = 2'd1; w_dl = 1'b0; end
      3'd2:    begin w_ch = 2'd2; w_dl = 1'b0; end
      3'd3:    begin w_ch = 2'd0; w_dl = 1'b1; end
      3'd4:    begin w_ch = 2'd1; w_dl = 1'b1; end
      3'd5:    begin w_ch = 2'd2; w_dl = 1'b1; end
      default: begin w_ch = 2'd0; w_dl = 1'b0; end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int m = 0; m < 2; m++)
        for (int c = 0; c < 3; c++)
          for (int k = 0; k < 2; k++)
            for (int s = 0; s < NSEG; s++)
              mem[m][c][k][s] <= '0;
    end else if (we_i && wmask_i[w_ch]) begin
      mem[wsel_i][w_ch][w_dl][widx_i] <= wdata_i;
    end
  end

  for (genvar c = 0; c < 3; c++) begin : g_rd
    assign base_o[c]  = mem[rsel_i][c][0][ridx_i[c]];
    assign delta_o[c] = mem[rsel_i][c][1][ridx_i[c]];
  end
endmodule

// File: rtl/gamma_chan_eval.sv
module gamma_chan_eval
  import gamma_pkg::*;
#(
  parameter int unsigned IN_W       = 12,
  parameter int unsigned OUT_W      = 12,
  parameter int unsigned NSEG       = 16,
  parameter int unsigned FRAC_W     = 6,
  parameter int unsigned SLOPE_W    = 12,
  parameter int unsigned SLOPE_FRAC = 8,
  parameter int unsigned IDX_W      = $clog2(NSEG)
) (
  input  lut_mode_e          mode_i,
  input  logic [IN_W-1:0]    x_i,
  input  logic [IN_W-1:0]    rgn_start_i,
  input  logic [SLOPE_W-1:0] start_slope_i,
  input  logic [OUT_W-1:0]   end_base_i,
  input  logic [SLOPE_W-1:0] end_slope_i,
  input  logic [OUT_W-1:0]   base_i,
  input  logic [OUT_W-1:0]   delta_i,
  output logic [IDX_W-1:0]   idx_o,
  output logic [OUT_W-1:0]   y_o
);
  localparam logic [31:0] SPAN   = 32'(NSEG) << FRAC_W;
  localparam logic [31:0] MAXV   = (32'd1 << OUT_W) - 32'd1;
  localparam logic [31:0] HALF_F = 32'd1 << (FRAC_W - 1);
  localparam logic [31:0] HALF_S = 32'd1 << (SLOPE_FRAC - 1);
  localparam int unsigned SQ_SH  = 2 * IN_W - OUT_W;

  logic [31:0] xw, off, frac, interp, lo, hi, sq, v;
  logic        below, above;

  always_comb begin
    xw     = 32'(x_i);
    below  = xw < 32'(rgn_start_i);
    off    = xw - 32'(rgn_start_i);
    above  = !below && (off >= SPAN);
    frac   = 32'(off[FRAC_W-1:0]);
    interp = 32'(base_i) + ((32'(delta_i) * frac + HALF_F) >> FRAC_W);
    lo     = (xw * 32'(start_slope_i) + HALF_S) >> SLOPE_FRAC;
    hi     = 32'(end_base_i) + (((off - SPAN) * 32'(end_slope_i) + HALF_S) >> SLOPE_FRAC);
    sq     = (xw * xw) >> SQ_SH;
    unique case (mode_i)
      MODE_RAM_A, MODE_RAM_B: v = below ? lo : (above ? hi : interp);
      MODE_SQUARE:            v = sq;
      MODE_BLEND:             v = (sq + xw) >> 1;
      default:                v = xw;
    endcase
    y_o   = (v > MAXV) ? OUT_W'(MAXV) : OUT_W'(v);
    idx_o = off[FRAC_W +: IDX_W];
  end
endmodule

// File: rtl/gamma_pwl_lut.sv
module gamma_pwl_lut
  import gamma_pkg::*;
#(
  parameter int unsigned IN_W       = 12,
  parameter int unsigned OUT_W      = 12,
  parameter int unsigned NSEG       = 16,
  parameter int unsigned FRAC_W     = 6,
  parameter int unsigned SLOPE_W    = 12,
  parameter int unsigned SLOPE_FRAC = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [2:0]         mode_i,
  input  logic [IN_W-1:0]    rgn_start_i,
  input  logic [SLOPE_W-1:0] start_slope_i,
  input  logic [OUT_W-1:0]   end_base_i,
  input  logic [SLOPE_W-1:0] end_slope_i,
  input  logic               idx_clr_i,
  input  logic               wr_i,
  input  logic               wr_sel_i,
  input  logic [2:0]         wr_mask_i,
  input  logic [OUT_W-1:0]   wr_data_i,
  input  logic               pix_valid_i,
  input  logic [IN_W-1:0]    r_i,
  input  logic [IN_W-1:0]    g_i,
  input  logic [IN_W-1:0]    b_i,
  output logic               pix_valid_o,
  output logic [OUT_W-1:0]   r_o,
  output logic [OUT_W-1:0]   g_o,
  output logic [OUT_W-1:0]   b_o,
  output logic [3:0]         status_o
);
  localparam int unsigned IDX_W = $clog2(NSEG);

  lut_mode_e              mode_q;
  logic                   live_a, live_b, wr_go, bank_we;
  logic [IDX_W-1:0]       w_idx;
  logic [2:0]             w_sub;
  logic [2:0][IN_W-1:0]   px;
  logic [2:0][IDX_W-1:0]  rd_idx;
  logic [2:0][OUT_W-1:0]  rd_base, rd_delta, y_d, y_q;
  logic                   vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= MODE_BYPASS;
    else         mode_q <= lut_mode_e'(mode_i);
  end

  assign live_a   = (mode_q == MODE_RAM_A);
  assign live_b   = (mode_q == MODE_RAM_B);
  assign status_o = live_a ? STAT_A_LIVE : (live_b ? STAT_B_LIVE : STAT_NONE);

  gamma_host_port #(.NSEG(NSEG), .IDX_W(IDX_W)) u_port (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (idx_clr_i),
    .wr_i  (wr_i),
    .go_o  (wr_go),
    .idx_o (w_idx),
    .sub_o (w_sub)
  );

  // a write aimed at the live memory is dropped
  assign bank_we = wr_go && !(wr_sel_i ? live_b : live_a);

  gamma_lut_bank #(.NSEG(NSEG), .W(OUT_W), .IDX_W(IDX_W)) u_bank (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (bank_we),
    .wsel_i (wr_sel_i),
    .widx_i (w_idx),
    .wsub_i (w_sub),
    .wmask_i(wr_mask_i),
    .wdata_i(wr_data_i),
    .rsel_i (live_b),
    .ridx_i (rd_idx),
    .base_o (rd_base),
    .delta_o(rd_delta)
  );

  assign px = {b_i, g_i, r_i};

  for (genvar c = 0; c < 3; c++) begin : g_ch
    gamma_chan_eval #(
      .IN_W(IN_W), .OUT_W(OUT_W), .NSEG(NSEG), .FRAC_W(FRAC_W),
      .SLOPE_W(SLOPE_W), .SLOPE_FRAC(SLOPE_FRAC), .IDX_W(IDX_W)
    ) u_eval (
      .mode_i       (mode_q),
      .x_i          (px[c]),
      .rgn_start_i  (rgn_start_i),
      .start_slope_i(start_slope_i),
      .end_base_i   (end_base_i),
      .end_slope_i  (end_slope_i),
      .base_i       (rd_base[c]),
      .delta_i      (rd_delta[c]),
      .idx_o        (rd_idx[c]),
      .y_o          (y_d[c])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      y_q   <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= pix_valid_i;
      if (pix_valid_i) y_q <= y_d;
    end
  end

  assign pix_valid_o = vld_q;
  assign r_o = y_q[0];
  assign g_o = y_q[1];
  assign b_o = y_q[2];
endmodule

// File: rtl/gamma_pwl_lut_chk.sv
module gamma_pwl_lut_chk #(
  parameter int unsigned IN_W  = 12,
  parameter int unsigned OUT_W = 12
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [2:0]       mode_i,
  input logic [2:0]       mode_q,
  input logic [2:0]       w_sub,
  input logic             pix_valid_i,
  input logic [IN_W-1:0]  r_i,
  input logic             pix_valid_o,
  input logic [OUT_W-1:0] r_o,
  input logic [OUT_W-1:0] g_o,
  input logic [OUT_W-1:0] b_o,
  input logic [3:0]       status_o
);
  logic past_ok;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  a_r2_status_follows_mode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |-> status_o == (($past(mode_i) == 3'd3) ? 4'd9 :
                             (($past(mode_i) == 3'd4) ? 4'd10 : 4'd0)));

  a_r3_valid_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |-> pix_valid_o == $past(pix_valid_i));

  a_r3_hold_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && !$past(pix_valid_i)) |-> ($stable(r_o) && $stable(g_o) && $stable(b_o)));

  a_r3_bypass_passthru: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $past(pix_valid_i) && $past(mode_q) == 3'd0 && IN_W == OUT_W)
      |-> r_o == OUT_W'($past(r_i)));

  a_r5_word_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    w_sub <= 3'd5);
endmodule

bind gamma_pwl_lut gamma_pwl_lut_chk #(.IN_W(IN_W), .OUT_W(OUT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .mode_i     (mode_i),
  .mode_q     (mode_q),
  .w_sub      (w_sub),
  .pix_valid_i(pix_valid_i),
  .r_i        (r_i),
  .pix_valid_o(pix_valid_o),
  .r_o        (r_o),
  .g_o        (g_o),
  .b_o        (b_o),
  .status_o   (status_o)
);

// File: tb/gamma_pwl_lut_bench.sv
`timescale 1ns/1ps
module gamma_pwl_lut_bench;
  localparam int NSEG = 16;
  localparam int RS   = 256;
  localparam int SS   = 200;
  localparam int EB   = 3000;
  localparam int ES   = 512;
  localparam int MAXV = 4095;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [2:0]  mode_i = '0;
  logic        idx_clr_i = 1'b0, wr_i = 1'b0, wr_sel_i = 1'b0;
  logic [2:0]  wr_mask_i = 3'd7;
  logic [11:0] wr_data_i = '0;
  logic        pix_valid_i = 1'b0;
  logic [11:0] r_i = '0, g_i = '0, b_i = '0;
  logic        pix_valid_o;
  logic [11:0] r_o, g_o, b_o;
  logic [3:0]  status_o;

  always #2.5 clk_i = ~clk_i;

  gamma_pwl_lut u_gamma_pwl_lut (
    .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode_i),
    .rgn_start_i(12'(RS)), .start_slope_i(12'(SS)),
    .end_base_i(12'(EB)), .end_slope_i(12'(ES)),
    .idx_clr_i(idx_clr_i), .wr_i(wr_i), .wr_sel_i(wr_sel_i),
    .wr_mask_i(wr_mask_i), .wr_data_i(wr_data_i),
    .pix_valid_i(pix_valid_i), .r_i(r_i), .g_i(g_i), .b_i(b_i),
    .pix_valid_o(pix_valid_o), .r_o(r_o), .g_o(g_o), .b_o(b_o),
    .status_o(status_o)
  );

  int    checks = 0, errors = 0;
  string cur_req = "R1";
  bit    armed = 0;

  // behavioural reference model
  int m_ram [2][3][2][NSEG];
  int m_mode, m_idx, m_sub;
  int e_y [3];
  int e_valid, e_status;

  function automatic int sat(int v);
    return (v > MAXV) ? MAXV : v;
  endfunction

  function automatic int model_y(int x, int c);
    int b, d, seg, f, ram;
    if (m_mode == 1) return sat((x * x) >>> 12);
    if (m_mode == 2) return sat((((x * x) >>> 12) + x) >>> 1);
    if (m_mode != 3 && m_mode != 4) return sat(x);
    ram = (m_mode == 4) ? 1 : 0;
    if (x < RS) return sat((x * SS + 128) >>> 8);
    if (x - RS >= NSEG * 64) return sat(EB + (((x - RS - NSEG * 64) * ES + 128) >>> 8));
    seg = (x - RS) / 64;
    f   = (x - RS) % 64;
    b   = m_ram[ram][c][0][seg];
    d   = m_ram[ram][c][1][seg];
    return sat(b + ((d * f + 32) >>> 6));
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      foreach (m_ram[a, b2, c2, d2]) m_ram[a][b2][c2][d2] = 0;
      m_mode = 0; m_idx = 0; m_sub = 0;
      e_y[0] = 0; e_y[1] = 0; e_y[2] = 0;
      e_valid = 0; e_status = 0;
    end else begin
      if (pix_valid_i) begin
        e_y[0] = model_y(int'(r_i), 0);
        e_y[1] = model_y(int'(g_i), 1);
        e_y[2] = model_y(int'(b_i), 2);
      end
      e_valid = int'(pix_valid_i);
      if (idx_clr_i) begin
        m_idx = 0; m_sub = 0;
      end else if (wr_i) begin
        if (!((m_mode == 3 && !wr_sel_i) || (m_mode == 4 && wr_sel_i)) && wr_mask_i[m_sub % 3])
          m_ram[wr_sel_i][m_sub % 3][m_sub / 3][m_idx] = int'(wr_data_i);
        if (m_sub == 5) begin
          m_sub = 0;
          m_idx = (m_idx + 1) % NSEG;
        end else m_sub = m_sub + 1;
      end
      m_mode   = int'(mode_i);
      e_status = (m_mode == 3) ? 9 : (m_mode == 4) ? 10 : 0;
    end
  end

  always @(negedge clk_i) begin
    if (rst_ni && armed) begin
      checks++;
      if (int'(r_o) != e_y[0] || int'(g_o) != e_y[1] || int'(b_o) != e_y[2] ||
          int'(pix_valid_o) != e_valid || int'(status_o) != e_status) begin
        errors++;
        $display("FAIL %s act=%0d/%0d/%0d v%0d s%0d exp=%0d/%0d/%0d v%0d s%0d", cur_req,
                 r_o, g_o, b_o, pix_valid_o, status_o,
                 e_y[0], e_y[1], e_y[2], e_valid, e_status);
      end
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic pix(int r, int g, int b);
    @(negedge clk_i);
    pix_valid_i = 1'b1; wr_i = 1'b0; idx_clr_i = 1'b0;
    r_i = 12'(r); g_i = 12'(g); b_i = 12'(b);
  endtask

  task automatic idle();
    @(negedge clk_i);
    pix_valid_i = 1'b0; wr_i = 1'b0; idx_clr_i = 1'b0;
  endtask

  task automatic set_mode(int m);
    @(negedge clk_i);
    pix_valid_i = 1'b0; wr_i = 1'b0; idx_clr_i = 1'b0;
    mode_i = 3'(m);
  endtask

  task automatic clr(bit with_wr, int data);
    @(negedge clk_i);
    pix_valid_i = 1'b0; idx_clr_i = 1'b1; wr_i = with_wr; wr_data_i = 12'(data);
  endtask

  task automatic wr(bit sel, logic [2:0] mask, int data);
    @(negedge clk_i);
    pix_valid_i = 1'b0; idx_clr_i = 1'b0; wr_i = 1'b1;
    wr_sel_i = sel; wr_mask_i = mask; wr_data_i = 12'(data);
  endtask

  function automatic int word(int e, int s, int seed);
    return (s < 3) ? (e * 170 + s * 7 + seed) : (140 + (s - 3) * 4 + e + seed / 2);
  endfunction

  task automatic load(bit sel, logic [2:0] mask, int seed, int extra);
    clr(1'b0, 0);
    for (int e = 0; e < NSEG; e++)
      for (int s = 0; s < 6; s++) wr(sel, mask, word(e, s, seed));
    for (int k = 0; k < extra; k++) wr(sel, mask, 4000 - k * 10);
    idle();
  endtask

  task automatic probe();
    pix(256, 300, 1279);
    pix(600, 1000, 257);
    pix(319, 1279, 900);
    idle();
    pix(700, 256 + 64 * 15 + 40, 1100);
    idle();
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1", int'(r_o) + int'(g_o) + int'(b_o), 0);
    chk("R1", int'(pix_valid_o), 0);
    chk("R1", int'(status_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1", int'(status_o), 0);
    armed = 1;

    cur_req = "R3";
    pix(0, 100, 4095); idle(); idle();
    pix(1234, 2048, 7); pix(5, 6, 4000); idle();
    set_mode(6);
    pix(321, 654, 987); idle();

    cur_req = "R4";
    set_mode(1);
    pix(4095, 2048, 1000); pix(64, 3000, 1); idle();
    set_mode(2);
    pix(4095, 2048, 1000); pix(64, 3000, 1); idle();

    cur_req = "R2";
    set_mode(3); idle();
    chk("R2", int'(status_o), 9);
    set_mode(4); idle();
    chk("R2", int'(status_o), 10);
    set_mode(0); idle();
    chk("R2", int'(status_o), 0);

    cur_req = "R5";
    load(1'b0, 3'd7, 0, 0);
    set_mode(3); idle();
    cur_req = "R8";
    probe();
    pix(256 + 64 * 7 + 63, 256 + 64 * 3, 256 + 1023);
    idle();
    cur_req = "R9";
    pix(0, 1, 255); pix(128, 200, 17); idle();
    cur_req = "R10";
    pix(1280, 1290, 1500); pix(1281, 1700, 1799); idle();
    cur_req = "R11";
    pix(4095, 2000, 3000); idle();

    cur_req = "R7";
    load(1'b0, 3'd7, 40, 0);
    probe();
    load(1'b1, 3'd7, 20, 0);
    probe();

    cur_req = "R6";
    load(1'b1, 3'b101, 35, 0);
    set_mode(4); idle();
    chk("R2", int'(status_o), 10);
    probe();
    load(1'b0, 3'b010, 9, 0);
    set_mode(3); idle();
    probe();

    cur_req = "R5";
    set_mode(0); idle();
    load(1'b1, 3'd7, 5, 6);
    clr(1'b1, 3900);
    wr(1'b1, 3'd7, 111);
    idle();
    set_mode(4); idle();
    probe();
    pix(256, 257, 300); idle();

    cur_req = "R3";
    set_mode(0); idle();
    pix(11, 22, 33); idle(); idle();

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule